// File: doc/BRIEF.md
# Trimmed Real-Time-Clock Prescaler

This block runs on the 32.768 kHz oscillator clock. It divides that clock into a 1 Hz strobe that drives the calendar counters, and into a 512 Hz square wave that is used to measure the oscillator error. A signed trim code corrects the 1 Hz rate. Trimming happens at the start of every correction window. During the first cycles of the window, the prescaler either advances by two per input cycle, which adds counts, or holds still, which drops counts. The raw oscillator clock can also be forwarded to a dedicated output pin. That forwarded clock is never trimmed.

Software reaches the block through a small register port with two byte-wide registers. The control register holds the calibration-mode bit and the clock-forward enable. The trim register holds the magnitude and the sign. At reset, the trim register loads the factory value presented on input pins, and the control bits clear. Calibration mode has three effects: it unlocks the trim register, it switches the shared calibration/power-fail pin from the power-fail input to the 512 Hz tone, and it drives the temperature-compensation enable low.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: A synchronous active-low reset clears the prescaler, the window counter, the calibration-mode bit and the clock-forward enable. The same reset loads the trim magnitude and sign from the factory inputs. While in reset, register 0 reads 0, register 1 reads {sign,0,magnitude}, the temperature-compensation enable is 1 and the forwarded clock is low.
- R2: With a zero trim magnitude, the tick output pulses for exactly one cycle every 2^DIV_W input cycles. The first pulse appears 2^DIV_W cycles after reset is released.
- R3: When the sign is 1 (add), the prescaler advances by 2 during the first 2×magnitude cycles of each window of 2^WIN_LOG2 cycles. The first tick after reset therefore comes 2^DIV_W − 2×magnitude cycles after release.
- R4: When the sign is 0 (remove), the prescaler holds during the first 2×magnitude cycles of each window. The first tick comes 2^DIV_W + 2×magnitude cycles after release.
- R5: In calibration mode, the shared pin carries prescaler bit TONE_BIT. Outside a trim phase this is a square wave that is 32 cycles high and 32 cycles low.
- R6: The tone is taken after the trim stage. With add trim of magnitude 8 and calibration mode set on the first cycle after reset, the tone first rises 16 cycles after release, not 32.
- R7: When the calibration-mode bit is 0, the shared pin follows the power-fail input combinationally.
- R8: The temperature-compensation enable is 0 while the calibration-mode bit is 1, and 1 otherwise.
- R9: The forwarded-clock output equals the input clock while the enable is 1, and is held low while it is 0.
- R10: Register 0 holds the calibration-mode bit in bit 0 and the forward enable in bit 1. Register 1 holds the magnitude in bits 5:0 and the sign in bit 7. A write to register 1 changes nothing unless the calibration-mode bit is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz oscillator clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| fac_mag_i | input | 6 | Factory trim magnitude loaded at reset |
| fac_sign_i | input | 1 | Factory trim sign loaded at reset (1 = add) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 trim |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| pfail_i | input | 1 | Power-fail input passed to the shared pin |
| cal_pfo_o | output | 1 | Shared pin: 512 Hz tone or power-fail |
| fout_o | output | 1 | Forwarded untrimmed oscillator clock |
| tick_o | output | 1 | One-cycle 1 Hz strobe |
| tcomp_en_o | output | 1 | Temperature-compensation enable |

## Verification
A wrong prescaler count, or a lost trim step, shows up as a shifted tick. With the trim applied at the start of the window, the shift is visible at the first tick after reset, to the exact cycle. A wrong window comparison shows up as an error of twice the magnitude in that same interval. The tone edges expose a corrupt prescaler within one 64-cycle period, because the first rise moves away from cycle 16 or cycle 32. A register that accepts a trim write without calibration mode shows up immediately on readback of the trim register.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
    localparam int CAL_W  = 6;
    localparam int DATA_W = 8;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_TRIM = 1'b1;

    typedef struct packed {
        logic             cal_mode;
        logic             fwd_en;
        logic [CAL_W-1:0] mag;
        logic             sign;
    } trim_regs_t;
endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
    import rtc_trim_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CAL_W-1:0]  fac_mag_i,
    input  logic              fac_sign_i,
    input  logic              we_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cal_mode_o,
    output logic              fwd_en_o,
    output logic [CAL_W-1:0]  mag_o,
    output logic              sign_o
);
    trim_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            if (addr_i == ADDR_CTRL) begin
                regs_d.cal_mode = wdata_i[0];
                regs_d.fwd_en   = wdata_i[1];
            end else if (regs_q.cal_mode) begin
                regs_d.mag  = wdata_i[CAL_W-1:0];
                regs_d.sign = wdata_i[DATA_W-1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q.cal_mode <= 1'b0;
            regs_q.fwd_en   <= 1'b0;
            regs_q.mag      <= fac_mag_i;
            regs_q.sign     <= fac_sign_i;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTRL) begin
            rdata_o[0] = regs_q.cal_mode;
            rdata_o[1] = regs_q.fwd_en;
        end else begin
            rdata_o[CAL_W-1:0] = regs_q.mag;
            rdata_o[DATA_W-1]  = regs_q.sign;
        end
    end

    assign cal_mode_o = regs_q.cal_mode;
    assign fwd_en_o   = regs_q.fwd_en;
    assign mag_o      = regs_q.mag;
    assign sign_o     = regs_q.sign;
endmodule

// File: rtl/rtc_trim_stepper.sv
module rtc_trim_stepper
    import rtc_trim_pkg::*;
#(
    parameter int WIN_LOG2 = 21
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CAL_W-1:0] mag_i,
    input  logic             sign_i,
    output logic [1:0]       step_o,
    output logic             in_trim_o
);
    typedef struct packed {
        logic [WIN_LOG2-1:0] win;
    } step_state_t;

    step_state_t st_d, st_q;
    logic [WIN_LOG2-1:0] span;

    assign span      = WIN_LOG2'({mag_i, 1'b0});
    assign in_trim_o = (st_q.win < span);

    always_comb begin
        st_d     = st_q;
        st_d.win = st_q.win + 1'b1;
        if (in_trim_o) begin
            step_o = sign_i ? 2'd2 : 2'd0;
        end else begin
            step_o = 2'd1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider #(
    parameter int DIV_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       step_i,
    output logic [DIV_W-1:0] pre_o,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic             tick;
    } div_state_t;

    div_state_t dv_d, dv_q;
    logic [DIV_W:0] sum;

    always_comb begin
        sum       = {1'b0, dv_q.pre} + {{(DIV_W-1){1'b0}}, step_i};
        dv_d.pre  = sum[DIV_W-1:0];
        dv_d.tick = sum[DIV_W];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign pre_o  = dv_q.pre;
    assign tick_o = dv_q.tick;
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int DIV_W    = 15,
    parameter int WIN_LOG2 = 21,
    parameter int TONE_BIT = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CAL_W-1:0]  fac_mag_i,
    input  logic              fac_sign_i,
    input  logic              reg_we_i,
    input  logic              reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              pfail_i,
    output logic              cal_pfo_o,
    output logic              fout_o,
    output logic              tick_o,
    output logic              tcomp_en_o
);
    logic             cal_mode;
    logic             fwd_en;
    logic [CAL_W-1:0] mag;
    logic             sign;
    logic [1:0]       step;
    logic             in_trim;
    logic [DIV_W-1:0] pre;
    logic             tone;

    rtc_trim_regs u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fac_mag_i  (fac_mag_i),
        .fac_sign_i (fac_sign_i),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .cal_mode_o (cal_mode),
        .fwd_en_o   (fwd_en),
        .mag_o      (mag),
        .sign_o     (sign)
    );

    rtc_trim_stepper #(.WIN_LOG2(WIN_LOG2)) u_stepper (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mag_i     (mag),
        .sign_i    (sign),
        .step_o    (step),
        .in_trim_o (in_trim)
    );

    rtc_trim_divider #(.DIV_W(DIV_W)) u_divider (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (step),
        .pre_o  (pre),
        .tick_o (tick_o)
    );

    assign tone       = pre[TONE_BIT];
    assign cal_pfo_o  = cal_mode ? tone : pfail_i;
    assign fout_o     = clk_i & fwd_en;
    assign tcomp_en_o = ~cal_mode;
endmodule

// File: rtl/rtc_trim_prescaler_chk.sv
module rtc_trim_prescaler_chk #(
    parameter int DIV_W = 15
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_o,
    input logic [DIV_W-1:0] pre,
    input logic             in_trim,
    input logic             sign,
    input logic             cal_mode,
    input logic             reg_we_i,
    input logic             reg_addr_i,
    input logic [5:0]       mag
);
    // R1: reset leaves a cleared prescaler, no tick and calibration mode off
    a_r1_reset_clears: assert property (@(posedge clk_i)
        !rst_ni |=> (pre == '0 && !tick_o && !cal_mode));

    // R2: the tick lasts a single cycle
    a_r2_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

    // R2: the tick coincides with the prescaler wrapping
    a_r2_tick_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (pre < DIV_W'(2)));

    // R2: outside the trim phase the prescaler advances by one
    a_r2_plain_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_trim |=> (pre == DIV_W'($past(pre) + 1'b1)));

    // R4: a remove trim holds the prescaler
    a_r4_remove_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_trim && !sign) |=> $stable(pre));

    // R10: trim writes outside calibration mode leave the trim unchanged
    a_r10_trim_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i && !cal_mode) |=> ($stable(mag) && $stable(sign)));
endmodule

bind rtc_trim_prescaler rtc_trim_prescaler_chk #(.DIV_W(DIV_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_o     (tick_o),
    .pre        (pre),
    .in_trim    (in_trim),
    .sign       (sign),
    .cal_mode   (cal_mode),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .mag        (mag)
);

// File: tb/test_rtc_trim_prescaler.sv
module test_rtc_trim_prescaler;
    localparam int DIV_W    = 10;
    localparam int WIN_LOG2 = 12;
    localparam int TONE_BIT = 5;
    localparam int FULL     = 1 << DIV_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] fac_mag = '0;
    logic       fac_sign = 1'b0;
    logic       we = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pfail = 1'b0;
    logic       cal_pfo;
    logic       fout;
    logic       tick;
    logic       tcomp_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rtc_trim_prescaler #(.DIV_W(DIV_W), .WIN_LOG2(WIN_LOG2), .TONE_BIT(TONE_BIT)) i_rtc_trim_prescaler (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .fac_mag_i   (fac_mag),
        .fac_sign_i  (fac_sign),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pfail_i     (pfail),
        .cal_pfo_o   (cal_pfo),
        .fout_o      (fout),
        .tick_o      (tick),
        .tcomp_en_o  (tcomp_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_reset(input logic [5:0] m, input logic s);
        rst_n    = 1'b0;
        fac_mag  = m;
        fac_sign = s;
        repeat (3) @(negedge clk);
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // releases reset at a falling edge, returns cycles until tick is seen
    task automatic cycles_to_tick(output int n);
        n = 0;
        rst_n = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 4000);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        hold_reset(6'd37, 1'b1);
        reg_read(1'b0, d);
        check(d == 8'h00, "R1 ctrl after reset", d, 0);
        reg_read(1'b1, d);
        check(d == 8'hA5, "R1 trim loads factory", d, 8'hA5);
        check(tcomp_en == 1'b1, "R1 tcomp enable", tcomp_en, 1);
        @(posedge clk); #1;
        check(fout == 1'b0, "R1 forward clock low", fout, 0);
    endtask

    task automatic t_untrimmed();
        int n;
        hold_reset(6'd0, 1'b0);
        cycles_to_tick(n);
        check(n == FULL, "R2 first tick", n, FULL);
        @(negedge clk);
        check(tick == 1'b0, "R2 single-cycle tick", tick, 0);
        n = 1;
        while (!tick && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(n == FULL, "R2 tick period", n, FULL);
    endtask

    task automatic t_trim(input logic [5:0] m, input logic s, input string req);
        int n;
        int exp;
        hold_reset(m, s);
        exp = s ? FULL - 2 * int'(m) : FULL + 2 * int'(m);
        cycles_to_tick(n);
        check(n == exp, req, n, exp);
    endtask

    task automatic t_tone();
        int n;
        int run;
        hold_reset(6'd8, 1'b1);
        rst_n = 1'b1;
        we = 1'b1; addr = 1'b0; wdata = 8'h01;
        @(negedge clk);
        we = 1'b0;
        n = 1;
        check(tcomp_en == 1'b0, "R8 tcomp low in cal mode", tcomp_en, 0);
        while (!cal_pfo && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(n == 16, "R6 tone rise after add trim", n, 16);
        run = 0;
        while (cal_pfo && run < 200) begin
            @(negedge clk);
            run++;
        end
        check(run == 32, "R5 tone high time", run, 32);
        run = 0;
        while (!cal_pfo && run < 200) begin
            @(negedge clk);
            run++;
        end
        check(run == 32, "R5 tone low time", run, 32);
        reg_write(1'b0, 8'h00);
        check(tcomp_en == 1'b1, "R8 tcomp back high", tcomp_en, 1);
    endtask

    task automatic t_pin_pass();
        hold_reset(6'd0, 1'b0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        pfail = 1'b1; #1;
        check(cal_pfo == 1'b1, "R7 pin follows pfail high", cal_pfo, 1);
        pfail = 1'b0; #1;
        check(cal_pfo == 1'b0, "R7 pin follows pfail low", cal_pfo, 0);
    endtask

    task automatic t_forward();
        hold_reset(6'd0, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(fout == 1'b0, "R9 held low when disabled", fout, 0);
        reg_write(1'b0, 8'h02);
        @(posedge clk); #1;
        check(fout == 1'b1, "R9 high with clock", fout, 1);
        @(negedge clk); #1;
        check(fout == 1'b0, "R9 low with clock", fout, 0);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        hold_reset(6'd3, 1'b0);
        rst_n = 1'b1;
        reg_write(1'b1, 8'h85);
        reg_read(1'b1, d);
        check(d == 8'h03, "R10 write ignored outside cal mode", d, 3);
        reg_write(1'b0, 8'h01);
        reg_write(1'b1, 8'h85);
        reg_read(1'b1, d);
        check(d == 8'h85, "R10 write accepted in cal mode", d, 8'h85);
        reg_write(1'b0, 8'h00);
        reg_write(1'b1, 8'h2A);
        reg_read(1'b1, d);
        check(d == 8'h85, "R10 locked again", d, 8'h85);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_untrimmed();
        t_trim(6'd63, 1'b1, "R3 full add");
        t_trim(6'd5,  1'b1, "R3 small add");
        t_trim(6'd63, 1'b0, "R4 full remove");
        t_trim(6'd9,  1'b0, "R4 small remove");
        t_tone();
        t_pin_pass();
        t_forward();
        t_lock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule